// File: doc/BRIEF.md
# Debug Breakpoint Status and Enable Unit

This unit keeps the debug status register and the debug control register of a small processor core and decides when the core must take a debug exception. Four external comparators report breakpoint matches as single-cycle pulses. The unit also receives the retire strobe together with the trap flag, a decoded debug-register access from the instruction decoder, a task-switch strobe that carries the incoming task's trap bit, and the debug-extensions bit from the core's control logic. For every cycle it merges all of these events into one registered debug exception request. It also raises an undefined-opcode request, updates the sticky status bits and the enables, and returns read data for the accessed register.

Every breakpoint that matches is recorded, whether or not it is armed. Only armed breakpoints trap. A breakpoint is armed by a local enable, which a task switch clears, or by a global enable, which survives task switches. An optional guard makes any debug-register access trap before it takes effect. The debug-extensions bit decides whether register indices 4 and 5 are illegal or are aliases of indices 6 and 7.

Top module: `dbg_trap_unit`

## Requirements
- R1: After a synchronous reset the status register reads 0xFFFF1FF0 (all writable bits 0, all reserved bits 1), the control register reads 0, and neither request output is asserted.
- R2: A match pulse on breakpoint i sets status bit i (bits 3..0) whatever the enables hold.
- R3: A match on breakpoint i raises the debug request only when its local enable (control bit 2i) or its global enable (control bit 2i+1) is 1. A set global enable arms the breakpoint even when its local enable is 0.
- R4: A task switch clears the local enables (control bits 0, 2, 4, 6) and leaves the global enables (bits 1, 3, 5, 7) and all other control bits unchanged.
- R5: A task switch whose trap bit is 1 sets status bit 15 and raises the debug request.
- R6: A retire with the trap flag at 1 sets status bit 14 and raises the debug request. A retire with the trap flag at 0 changes nothing.
- R7: While the access guard (control bit 13) is 1, any access that is not undefined sets status bit 13, raises the debug request, suppresses the access (no write, read data 0) and clears the guard.
- R8: With debug extensions at 1, an access to index 4 or 5 raises the undefined-opcode request and changes no register. It does not trigger the guard (bit 13 is neither set in status nor cleared in control), and it returns read data 0.
- R9: With debug extensions at 0, indices 4 and 5 act exactly as indices 6 (status) and 7 (control) for reads and writes.
- R10: Status bits are sticky and change only through a write to index 6, which loads the writable mask 0x0000E00F. A write to index 7 loads the control mask 0xFFFF20FF. Unmasked bits keep their fixed values.
- R11: When several sources fire in one cycle, all of their status bits are set and the debug request is high for exactly that one following cycle.
- R12: Both request outputs are registered and are high in the cycle after the triggering input. Read data is combinational in the access cycle, and reads of indices 0 to 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bp_hit | input | NUM_BP | Per-breakpoint match pulses |
| retire_vld | input | 1 | An instruction retired this cycle |
| trap_flag | input | 1 | Single-step flag of the retiring instruction |
| acc_vld | input | 1 | Decoded debug-register access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_idx | input | IDX_W | Debug-register index 0..7 |
| acc_wdata | input | DW | Write data |
| task_sw | input | 1 | Task-switch strobe |
| task_trap | input | 1 | Incoming task's debug trap bit |
| dbg_ext_en | input | 1 | Debug-extensions control bit |
| dbg_exc_req | output | 1 | Debug exception request pulse |
| ud_exc_req | output | 1 | Undefined-opcode exception request pulse |
| acc_rdata | output | DW | Read data for the current access |
| stat_o | output | DW | Status register readback |
| ctrl_o | output | DW | Control register readback |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the access guard and the undefined-opcode check on one access. The bench sets the guard and then issues an access to index 4 with extensions enabled. It expects the undefined request alone, with status bit 13 clear and the guard still set. The second pair is breakpoint, single-step, task-trap and guard events all arriving together. The bench drives all four in one cycle. It expects every matching status bit set, the guard cleared, the local enables cleared, and a debug request that lasts exactly one cycle.

// File: rtl/dbg_trap_pkg.sv
package dbg_trap_pkg;

    localparam int DBG_DW     = 32;
    localparam int DBG_NUM_BP = 4;
    localparam int DBG_IDX_W  = 3;

    // status bit positions
    localparam int ST_BD = 13;
    localparam int ST_BS = 14;
    localparam int ST_BT = 15;
    // control bit positions
    localparam int CT_GD = 13;
    localparam int CT_HI = 16;

    localparam logic [DBG_IDX_W-1:0] IDX_STAT = 3'd6;
    localparam logic [DBG_IDX_W-1:0] IDX_CTRL = 3'd7;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_UD,
        ACC_GUARD,
        ACC_RD,
        ACC_WR
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e             kind;
        logic [DBG_IDX_W-1:0]  idx;
    } acc_dec_t;

    typedef struct packed {
        logic guard;
        logic step;
        logic task_trap;
        logic bp;
    } dbg_src_t;

    function automatic logic [DBG_DW-1:0] stat_wmask(input int nbp);
        logic [DBG_DW-1:0] m;
        m = '0;
        for (int i = 0; i < nbp; i++) m[i] = 1'b1;
        m[ST_BD] = 1'b1;
        m[ST_BS] = 1'b1;
        m[ST_BT] = 1'b1;
        return m;
    endfunction

    function automatic logic [DBG_DW-1:0] ctrl_wmask(input int nbp);
        logic [DBG_DW-1:0] m;
        m = '0;
        for (int i = 0; i < 2*nbp; i++) m[i] = 1'b1;
        m[CT_GD] = 1'b1;
        for (int i = CT_HI; i < DBG_DW; i++) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [DBG_DW-1:0] local_en_mask(input int nbp);
        logic [DBG_DW-1:0] m;
        m = '0;
        for (int i = 0; i < nbp; i++) m[2*i] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/dbg_acc_decode.sv
module dbg_acc_decode
    import dbg_trap_pkg::*;
#(
    parameter int IDX_W = DBG_IDX_W
) (
    input  logic             acc_vld,
    input  logic             acc_wr,
    input  logic [IDX_W-1:0] acc_idx,
    input  logic             dbg_ext_en,
    input  logic             guard_en,
    output acc_dec_t         dec
);
    logic alias_slot;

    assign alias_slot = (acc_idx == IDX_W'(4)) || (acc_idx == IDX_W'(5));

    always_comb begin
        dec.kind = ACC_NONE;
        dec.idx  = acc_idx;
        if (acc_vld) begin
            if (alias_slot && dbg_ext_en) begin
                dec.kind = ACC_UD;
            end else begin
                if (alias_slot) dec.idx = acc_idx | IDX_W'(2);
                if (guard_en)    dec.kind = ACC_GUARD;
                else if (acc_wr) dec.kind = ACC_WR;
                else             dec.kind = ACC_RD;
            end
        end
    end
endmodule

// File: rtl/dbg_bp_eval.sv
module dbg_bp_eval #(
    parameter int NUM_BP = 4
) (
    input  logic [NUM_BP-1:0]   bp_hit,
    input  logic [2*NUM_BP-1:0] en_field,
    output logic [NUM_BP-1:0]   armed,
    output logic                bp_trap
);
    for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
        assign armed[i] = en_field[2*i] | en_field[2*i+1];
    end

    assign bp_trap = |(bp_hit & armed);
endmodule

// File: rtl/dbg_stat_reg.sv
module dbg_stat_reg
    import dbg_trap_pkg::*;
#(
    parameter int NUM_BP = DBG_NUM_BP,
    parameter int DW     = DBG_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] hw_set,
    input  logic          sw_we,
    input  logic [DW-1:0] sw_wdata,
    output logic [DW-1:0] stat
);
    localparam logic [DW-1:0] WMASK = stat_wmask(NUM_BP);
    localparam logic [DW-1:0] FIXED = ~WMASK;

    logic [DW-1:0] stat_q;
    logic [DW-1:0] stat_d;

    always_comb begin
        stat_d = sw_we ? (sw_wdata & WMASK) : stat_q;
        stat_d = stat_d | (hw_set & WMASK);
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= stat_d;
    end

    assign stat = stat_q | FIXED;
endmodule

// File: rtl/dbg_ctrl_reg.sv
module dbg_ctrl_reg
    import dbg_trap_pkg::*;
#(
    parameter int NUM_BP = DBG_NUM_BP,
    parameter int DW     = DBG_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sw_we,
    input  logic [DW-1:0] sw_wdata,
    input  logic          guard_clr,
    input  logic          task_sw,
    output logic [DW-1:0] ctrl
);
    localparam logic [DW-1:0] WMASK = ctrl_wmask(NUM_BP);
    localparam logic [DW-1:0] LMASK = local_en_mask(NUM_BP);

    logic [DW-1:0] ctrl_q;
    logic [DW-1:0] ctrl_d;

    always_comb begin
        ctrl_d = sw_we ? (sw_wdata & WMASK) : ctrl_q;
        if (guard_clr) ctrl_d[CT_GD] = 1'b0;
        if (task_sw)   ctrl_d = ctrl_d & ~LMASK;
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_d;
    end

    assign ctrl = ctrl_q;
endmodule

// File: rtl/dbg_trap_unit.sv
module dbg_trap_unit
    import dbg_trap_pkg::*;
#(
    parameter int NUM_BP = DBG_NUM_BP,
    parameter int DW     = DBG_DW,
    parameter int IDX_W  = DBG_IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_BP-1:0] bp_hit,
    input  logic              retire_vld,
    input  logic              trap_flag,
    input  logic              acc_vld,
    input  logic              acc_wr,
    input  logic [IDX_W-1:0]  acc_idx,
    input  logic [DW-1:0]     acc_wdata,
    input  logic              task_sw,
    input  logic              task_trap,
    input  logic              dbg_ext_en,
    output logic              dbg_exc_req,
    output logic              ud_exc_req,
    output logic [DW-1:0]     acc_rdata,
    output logic [DW-1:0]     stat_o,
    output logic [DW-1:0]     ctrl_o
);
    acc_dec_t          dec;
    dbg_src_t          src;
    logic [NUM_BP-1:0] armed;
    logic [DW-1:0]     stat;
    logic [DW-1:0]     ctrl;
    logic [DW-1:0]     hw_set;
    logic              stat_we;
    logic              ctrl_we;
    logic              dbg_exc_q;
    logic              ud_exc_q;

    dbg_acc_decode #(.IDX_W(IDX_W)) dec_i (
        .acc_vld    (acc_vld),
        .acc_wr     (acc_wr),
        .acc_idx    (acc_idx),
        .dbg_ext_en (dbg_ext_en),
        .guard_en   (ctrl[CT_GD]),
        .dec        (dec)
    );

    dbg_bp_eval #(.NUM_BP(NUM_BP)) bp_i (
        .bp_hit   (bp_hit),
        .en_field (ctrl[2*NUM_BP-1:0]),
        .armed    (armed),
        .bp_trap  (src.bp)
    );

    assign src.step      = retire_vld & trap_flag;
    assign src.task_trap = task_sw & task_trap;
    assign src.guard     = (dec.kind == ACC_GUARD);

    always_comb begin
        hw_set               = '0;
        hw_set[NUM_BP-1:0]   = bp_hit;
        hw_set[ST_BD]        = src.guard;
        hw_set[ST_BS]        = src.step;
        hw_set[ST_BT]        = src.task_trap;
    end

    assign stat_we = (dec.kind == ACC_WR) && (dec.idx == IDX_STAT);
    assign ctrl_we = (dec.kind == ACC_WR) && (dec.idx == IDX_CTRL);

    dbg_stat_reg #(.NUM_BP(NUM_BP), .DW(DW)) stat_i (
        .clk      (clk),
        .rst      (rst),
        .hw_set   (hw_set),
        .sw_we    (stat_we),
        .sw_wdata (acc_wdata),
        .stat     (stat)
    );

    dbg_ctrl_reg #(.NUM_BP(NUM_BP), .DW(DW)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .sw_we     (ctrl_we),
        .sw_wdata  (acc_wdata),
        .guard_clr (src.guard),
        .task_sw   (task_sw),
        .ctrl      (ctrl)
    );

    always_comb begin
        acc_rdata = '0;
        if (dec.kind == ACC_RD) begin
            if (dec.idx == IDX_STAT)      acc_rdata = stat;
            else if (dec.idx == IDX_CTRL) acc_rdata = ctrl;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dbg_exc_q <= 1'b0;
            ud_exc_q  <= 1'b0;
        end else begin
            dbg_exc_q <= |src;
            ud_exc_q  <= (dec.kind == ACC_UD);
        end
    end

    assign dbg_exc_req = dbg_exc_q;
    assign ud_exc_req  = ud_exc_q;
    assign stat_o      = stat;
    assign ctrl_o      = ctrl;
endmodule

// File: rtl/dbg_trap_unit_chk.sv
module dbg_trap_unit_chk #(
    parameter int NUM_BP = 4,
    parameter int DW     = 32,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_BP-1:0] bp_hit,
    input logic              retire_vld,
    input logic              trap_flag,
    input logic              acc_vld,
    input logic [IDX_W-1:0]  acc_idx,
    input logic              task_sw,
    input logic              task_trap,
    input logic              dbg_ext_en,
    input logic              dbg_exc_req,
    input logic              ud_exc_req,
    input logic [DW-1:0]     stat_o,
    input logic [DW-1:0]     ctrl_o
);
    logic [NUM_BP-1:0] en_now;
    logic [NUM_BP-1:0] g_now;
    logic              ud_slot;
    logic              other_src;

    always_comb begin
        for (int i = 0; i < NUM_BP; i++) begin
            en_now[i] = ctrl_o[2*i] | ctrl_o[2*i+1];
            g_now[i]  = ctrl_o[2*i+1];
        end
    end

    assign ud_slot   = acc_vld && dbg_ext_en && (acc_idx == IDX_W'(4) || acc_idx == IDX_W'(5));
    assign other_src = (retire_vld && trap_flag) || (task_sw && task_trap) ||
                       (acc_vld && ctrl_o[13] && !ud_slot);

    // R2
    a_r2_hit_recorded: assert property (@(posedge clk) disable iff (rst)
        (bp_hit != '0) |=> ((stat_o[NUM_BP-1:0] & $past(bp_hit)) == $past(bp_hit)));

    // R3
    a_r3_disarmed_silent: assert property (@(posedge clk) disable iff (rst)
        ((bp_hit != '0) && ((bp_hit & en_now) == '0) && !other_src) |=> !dbg_exc_req);

    // R4
    a_r4_task_keeps_global: assert property (@(posedge clk) disable iff (rst)
        (task_sw && !acc_vld) |=> (ctrl_o[0] == 1'b0 && ctrl_o[2] == 1'b0 &&
                                   ctrl_o[4] == 1'b0 && ctrl_o[6] == 1'b0 &&
                                   $stable(g_now)));

    // R5
    a_r5_task_trap: assert property (@(posedge clk) disable iff (rst)
        (task_sw && task_trap) |=> (stat_o[15] && dbg_exc_req));

    // R6
    a_r6_single_step: assert property (@(posedge clk) disable iff (rst)
        (retire_vld && trap_flag) |=> (stat_o[14] && dbg_exc_req));

    // R7
    a_r7_guard_fires: assert property (@(posedge clk) disable iff (rst)
        (acc_vld && ctrl_o[13] && !ud_slot) |=> (dbg_exc_req && stat_o[13] && !ctrl_o[13]));

    // R8
    a_r8_undef_no_change: assert property (@(posedge clk) disable iff (rst)
        (ud_slot && !task_sw) |=> (ud_exc_req && $stable(ctrl_o)));

    // R12
    a_r12_ud_only_from_slot: assert property (@(posedge clk) disable iff (rst)
        !ud_slot |=> !ud_exc_req);
endmodule

bind dbg_trap_unit dbg_trap_unit_chk #(.NUM_BP(NUM_BP), .DW(DW), .IDX_W(IDX_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .bp_hit      (bp_hit),
    .retire_vld  (retire_vld),
    .trap_flag   (trap_flag),
    .acc_vld     (acc_vld),
    .acc_idx     (acc_idx),
    .task_sw     (task_sw),
    .task_trap   (task_trap),
    .dbg_ext_en  (dbg_ext_en),
    .dbg_exc_req (dbg_exc_req),
    .ud_exc_req  (ud_exc_req),
    .stat_o      (stat_o),
    .ctrl_o      (ctrl_o)
);

// File: tb/dbg_trap_unit_tb.sv
`timescale 1ns/1ps
module dbg_trap_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  bp_hit;
    logic        retire_vld, trap_flag;
    logic        acc_vld, acc_wr;
    logic [2:0]  acc_idx;
    logic [31:0] acc_wdata;
    logic        task_sw, task_trap, dbg_ext_en;
    logic        dbg_exc_req, ud_exc_req;
    logic [31:0] acc_rdata, stat_o, ctrl_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    dbg_trap_unit dut_i (
        .clk(clk), .rst(rst), .bp_hit(bp_hit), .retire_vld(retire_vld),
        .trap_flag(trap_flag), .acc_vld(acc_vld), .acc_wr(acc_wr),
        .acc_idx(acc_idx), .acc_wdata(acc_wdata), .task_sw(task_sw),
        .task_trap(task_trap), .dbg_ext_en(dbg_ext_en),
        .dbg_exc_req(dbg_exc_req), .ud_exc_req(ud_exc_req),
        .acc_rdata(acc_rdata), .stat_o(stat_o), .ctrl_o(ctrl_o)
    );

    typedef struct packed {
        logic [7:0]  rq;
        logic [3:0]  hit;
        logic        ret, tf, acc, wr;
        logic [2:0]  idx;
        logic [31:0] wdata;
        logic        tsw, ttb, ext;
        logic [31:0] estat, ectrl;
        logic        edbg, eud;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{8'd2,  4'b0001,0,0,0,0,3'd0,32'h0,        0,0,0,32'hFFFF1FF1,32'h00000000,1'b0,1'b0}, // R2 disarmed hit recorded
        '{8'd10, 4'b0000,0,0,1,1,3'd7,32'h00000004, 0,0,0,32'hFFFF1FF1,32'h00000004,1'b0,1'b0}, // R10 arm local 1
        '{8'd3,  4'b0010,0,0,0,0,3'd0,32'h0,        0,0,0,32'hFFFF1FF3,32'h00000004,1'b1,1'b0}, // R3 armed hit traps
        '{8'd10, 4'b0000,0,0,1,1,3'd6,32'h0,        0,0,0,32'hFFFF1FF0,32'h00000004,1'b0,1'b0}, // R10 clear status
        '{8'd9,  4'b0000,0,0,1,1,3'd5,32'h0000000C, 0,0,0,32'hFFFF1FF0,32'h0000000C,1'b0,1'b0}, // R9 alias 5->7
        '{8'd4,  4'b0000,0,0,0,0,3'd0,32'h0,        1,0,0,32'hFFFF1FF0,32'h00000008,1'b0,1'b0}, // R4 local cleared
        '{8'd3,  4'b0010,0,0,0,0,3'd0,32'h0,        0,0,0,32'hFFFF1FF2,32'h00000008,1'b1,1'b0}, // R3 global override
        '{8'd5,  4'b0000,0,0,0,0,3'd0,32'h0,        1,1,0,32'hFFFF9FF2,32'h00000008,1'b1,1'b0}, // R5 task trap
        '{8'd6,  4'b0000,1,0,0,0,3'd0,32'h0,        0,0,0,32'hFFFF9FF2,32'h00000008,1'b0,1'b0}, // R6 no flag
        '{8'd6,  4'b0000,1,1,0,0,3'd0,32'h0,        0,0,0,32'hFFFFDFF2,32'h00000008,1'b1,1'b0}, // R6 step
        '{8'd9,  4'b0000,0,0,1,1,3'd4,32'h0,        0,0,0,32'hFFFF1FF0,32'h00000008,1'b0,1'b0}, // R9 alias 4->6
        '{8'd8,  4'b0000,0,0,1,1,3'd5,32'hFFFFFFFF, 0,0,1,32'hFFFF1FF0,32'h00000008,1'b0,1'b1}, // R8 undef write
        '{8'd10, 4'b0000,0,0,1,1,3'd7,32'h00002008, 0,0,0,32'hFFFF1FF0,32'h00002008,1'b0,1'b0}, // R10 set guard
        '{8'd8,  4'b0000,0,0,1,0,3'd4,32'h0,        0,0,1,32'hFFFF1FF0,32'h00002008,1'b0,1'b1}, // R8 beats guard
        '{8'd7,  4'b0000,0,0,1,1,3'd6,32'h0,        0,0,0,32'hFFFF3FF0,32'h00000008,1'b1,1'b0}, // R7 guarded write
        '{8'd10, 4'b0000,0,0,1,1,3'd7,32'hFFFFFFFF, 0,0,0,32'hFFFF3FF0,32'hFFFF20FF,1'b0,1'b0}, // R10 ctrl mask
        '{8'd11, 4'b0100,1,1,1,0,3'd0,32'h0,        1,1,0,32'hFFFFFFF4,32'hFFFF00AA,1'b1,1'b0}, // R11 all at once
        '{8'd11, 4'b0000,0,0,0,0,3'd0,32'h0,        0,0,0,32'hFFFFFFF4,32'hFFFF00AA,1'b0,1'b0}, // R11 single pulse
        '{8'd10, 4'b0000,0,0,1,1,3'd6,32'h00000005, 0,0,0,32'hFFFF1FF5,32'hFFFF00AA,1'b0,1'b0}, // R10 status mask
        '{8'd3,  4'b1000,0,0,0,0,3'd0,32'h0,        0,0,0,32'hFFFF1FFD,32'hFFFF00AA,1'b1,1'b0}  // R3 global 3
    };

    task automatic chk(input int rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic idle_in();
        bp_hit = '0; retire_vld = 0; trap_flag = 0; acc_vld = 0; acc_wr = 0;
        acc_idx = '0; acc_wdata = '0; task_sw = 0; task_trap = 0; dbg_ext_en = 0;
    endtask

    task automatic rd(input logic [2:0] idx, input logic ext);
        acc_vld = 1; acc_wr = 0; acc_idx = idx; dbg_ext_en = ext;
        #1;
    endtask

    initial begin
        idle_in();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(1, "stat reset", stat_o, 32'hFFFF1FF0);
        chk(1, "ctrl reset", ctrl_o, 32'h0);
        chk(1, "dbg reset", {31'b0, dbg_exc_req}, 32'h0);
        chk(1, "ud reset", {31'b0, ud_exc_req}, 32'h0);

        for (int v = 0; v < NV; v++) begin
            bp_hit = VEC[v].hit; retire_vld = VEC[v].ret; trap_flag = VEC[v].tf;
            acc_vld = VEC[v].acc; acc_wr = VEC[v].wr; acc_idx = VEC[v].idx;
            acc_wdata = VEC[v].wdata; task_sw = VEC[v].tsw; task_trap = VEC[v].ttb;
            dbg_ext_en = VEC[v].ext;
            @(negedge clk);
            idle_in();
            chk(int'(VEC[v].rq), $sformatf("vec%0d stat", v), stat_o, VEC[v].estat);
            chk(int'(VEC[v].rq), $sformatf("vec%0d ctrl", v), ctrl_o, VEC[v].ectrl);
            chk(int'(VEC[v].rq), $sformatf("vec%0d dbg", v), {31'b0, dbg_exc_req}, {31'b0, VEC[v].edbg});
            chk(int'(VEC[v].rq), $sformatf("vec%0d ud", v), {31'b0, ud_exc_req}, {31'b0, VEC[v].eud});
        end

        // R12 combinational read of control, then register 2 reads zero
        rd(3'd7, 1'b0);
        chk(12, "read idx7", acc_rdata, 32'hFFFF00AA);
        acc_idx = 3'd2; #1;
        chk(12, "read idx2", acc_rdata, 32'h0);
        // R9 alias read of index 5
        acc_idx = 3'd5; #1;
        chk(9, "read idx5 alias", acc_rdata, 32'hFFFF00AA);
        // R8 illegal read returns zero, request next cycle only
        acc_idx = 3'd4; dbg_ext_en = 1'b1; #1;
        chk(8, "read idx4 undef", acc_rdata, 32'h0);
        chk(12, "ud not yet", {31'b0, ud_exc_req}, 32'h0);
        @(negedge clk);
        idle_in();
        chk(12, "ud pulse", {31'b0, ud_exc_req}, 32'h1);
        @(negedge clk);
        chk(12, "ud pulse ends", {31'b0, ud_exc_req}, 32'h0);
        chk(10, "stat untouched", stat_o, 32'hFFFF1FFD);

        // R7 guarded read returns zero
        acc_vld = 1; acc_wr = 1; acc_idx = 3'd7; acc_wdata = 32'h00002000;
        @(negedge clk);
        rd(3'd6, 1'b0);
        chk(7, "guarded read zero", acc_rdata, 32'h0);
        @(negedge clk);
        idle_in();
        chk(7, "guard cleared", {31'b0, ctrl_o[13]}, 32'h0);
        chk(7, "guard bd", {31'b0, stat_o[13]}, 32'h1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule